// File: doc/BRIEF.md
# Cascadable Dual 8-Bit Line Timer

This block holds two small up-counting interval timers that produce periodic request pulses, meant to start memory-to-register transfers or to raise interrupts once per video line or once every few lines. Timer 0 can count rising edges of an external horizontal-sync input. Timer 1 can count the matches of timer 0, which chains the two timers into a longer divider. Both timers can instead count ticks from a shared free-running prescaler.

Each timer counts up from zero. When the next count would reach its compare value, the counter restarts at zero and the timer emits a request that lasts one cycle. Each request also carries a five-bit start code. Software sees four byte registers: a run-control register, a mode register, and two compare registers. A read at a compare register's address returns that timer's live counter, not the compare value last written.

Top module: `line_timer_pair`

## Requirements
- R1: After reset, the run register, the mode register, both compare registers and both counters are zero. All four read addresses return 0, and no request is issued.
- R2: With the timer 0 clock field (mode bits 1-0) set to 00, timer 0 advances exactly once for each rising edge of `line_in`, after that input has been synchronised. With compare value N, timer 0 issues one request per N edges: a value of 1 gives a request on every edge, and a value of 2 gives a request on every second edge.
- R3: A compare value of 0 counts as 256. After 255 edges the counter reads 255 and no request has been issued; the 256th edge issues the request.
- R4: With the timer 1 clock field (mode bits 3-2) set to 00, timer 1 counts the matches of timer 0. A timer 1 request occurs in the same cycle as the timer 0 request that completes its count. With both compare values set to 1 and 2, 152 line edges give 152 timer 0 requests and 76 timer 1 requests.
- R5: Run bit 7 enables the prescaler. Clock field codes 01, 10 and 11 select prescaler taps at clk/2, clk/8 and clk/32. A tap-clocked timer receives no ticks while run bit 7 is 0.
- R6: Run bit 0 starts timer 0 and run bit 1 starts timer 1. While a timer's run bit is 0, its counter is held at 0 and it issues no requests.
- R7: Read addresses are decoded as 0 for the run register, 1 for the mode register, 2 for timer 0 and 3 for timer 1. Addresses 2 and 3 return the live counter, not the compare value.
- R8: Mode bits 7-4, which hold the operating-mode and PWM fields, are stored and read back unchanged. They have no effect on counting or on requests.
- R9: `req_code` is 0x10 in a cycle where timer 0 requests, and 0x11 where only timer 1 requests. Timer 0 wins when both request in the same cycle. In all other cycles `req_code` is 0.
- R10: Each request is a single-cycle pulse. A timer never requests in two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| line_in | input | 1 | External horizontal-sync pulse, asynchronous to `clk` |
| wr_en | input | 1 | Register write strobe |
| addr | input | 2 | Register address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for `addr` (combinational) |
| t0_req | output | 1 | Timer 0 match request pulse |
| t1_req | output | 1 | Timer 1 match request pulse |
| req_code | output | 5 | Start code of the winning request, or 0 |

## Verification
The bound checker watches rules that must hold on every cycle:
- A stopped timer stays silent and keeps its counter at zero.
- A request lasts one cycle.
- A cascaded timer 1 request coincides with a timer 0 request.
- A tap-clocked timer makes no requests while the prescaler is off.
- `req_code` is nonzero exactly when a request is present.

Only the bench's scenarios can show the counting behaviour:
- how many requests a given number of line edges produces;
- the 256-count treatment of compare value 0;
- the 152-to-76 cascade ratio;
- the prescaler intervals;
- that compare addresses read back live counts;
- that the upper mode bits are stored without effect.

// File: rtl/ltp_pkg.sv
package ltp_pkg;

   typedef enum logic [1:0] {
      ADDR_RUN  = 2'd0,
      ADDR_MODE = 2'd1,
      ADDR_TMR0 = 2'd2,
      ADDR_TMR1 = 2'd3
   } ltp_addr_e;

   // run-control bit positions
   localparam int unsigned RUN_BIT_T0  = 0;
   localparam int unsigned RUN_BIT_T1  = 1;
   localparam int unsigned RUN_BIT_PRE = 7;

   // mode register layout
   typedef struct packed {
      logic [1:0] op_mode;   // stored only
      logic [1:0] pwm_cfg;   // stored only
      logic [1:0] t1_clk;    // 00: timer 0 match, 01..11: prescaler taps
      logic [1:0] t0_clk;    // 00: line input,    01..11: prescaler taps
   } ltp_mode_t;

   localparam logic [4:0] CODE_T0 = 5'h10;
   localparam logic [4:0] CODE_T1 = 5'h11;

   localparam int unsigned N_TIMERS = 2;
   localparam int unsigned N_TAPS   = 3;

endpackage

// File: rtl/ltp_line_sync.sv
module ltp_line_sync #(
   parameter int unsigned STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic async_i,
   output logic rise_o
);
   logic [STAGES-1:0] sync_q;
   logic              last_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sync_q <= '0;
         last_q <= 1'b0;
      end else begin
         sync_q <= {sync_q[STAGES-2:0], async_i};
         last_q <= sync_q[STAGES-1];
      end
   end

   assign rise_o = sync_q[STAGES-1] & ~last_q;
endmodule

// File: rtl/ltp_prescaler.sv
module ltp_prescaler #(
   parameter int unsigned LOG_A = 1,
   parameter int unsigned LOG_B = 3,
   parameter int unsigned LOG_C = 5
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       en_i,
   output logic [2:0] tick_o
);
   localparam int unsigned PRE_W = LOG_C;

   function automatic int unsigned tap_log(input int unsigned idx);
      case (idx)
         0:       return LOG_A;
         1:       return LOG_B;
         default: return LOG_C;
      endcase
   endfunction

   logic [PRE_W-1:0] pre_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     pre_q <= '0;
      else if (!en_i) pre_q <= '0;
      else            pre_q <= pre_q + 1'b1;
   end

   for (genvar g = 0; g < 3; g++) begin : g_tap
      localparam int unsigned L = tap_log(g);
      assign tick_o[g] = en_i & (&pre_q[L-1:0]);
   end
endmodule

// File: rtl/ltp_channel.sv
module ltp_channel #(
   parameter int unsigned CNT_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run_i,
   input  logic             tick_i,
   input  logic [CNT_W-1:0] cmp_i,
   output logic [CNT_W-1:0] cnt_o,
   output logic             hit_o,
   output logic             req_o
);
   localparam logic [CNT_W:0] FULL = {1'b1, {CNT_W{1'b0}}};

   logic [CNT_W-1:0] cnt_q;
   logic             req_q;
   logic [CNT_W:0]   nxt;
   logic [CNT_W:0]   target;

   assign target = (cmp_i == '0) ? FULL : {1'b0, cmp_i};
   assign nxt    = {1'b0, cnt_q} + 1'b1;
   assign hit_o  = run_i & tick_i & (nxt == target);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
         req_q <= 1'b0;
      end else begin
         req_q <= hit_o;
         if (!run_i)      cnt_q <= '0;
         else if (tick_i) cnt_q <= hit_o ? '0 : nxt[CNT_W-1:0];
      end
   end

   assign cnt_o = cnt_q;
   assign req_o = req_q;
endmodule

// File: rtl/line_timer_pair.sv
module line_timer_pair
   import ltp_pkg::*;
#(
   parameter int unsigned CNT_W       = 8,
   parameter int unsigned BUS_W       = 8,
   parameter int unsigned SYNC_STAGES = 2,
   parameter int unsigned TAP_LOG_A   = 1,
   parameter int unsigned TAP_LOG_B   = 3,
   parameter int unsigned TAP_LOG_C   = 5,
   parameter logic [4:0]  VEC0        = CODE_T0,
   parameter logic [4:0]  VEC1        = CODE_T1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             line_in,
   input  logic             wr_en,
   input  logic [1:0]       addr,
   input  logic [BUS_W-1:0] wdata,
   output logic [BUS_W-1:0] rdata,
   output logic             t0_req,
   output logic             t1_req,
   output logic [4:0]       req_code
);
   // elaboration-time parameter checks
   if (BUS_W != 8) begin : g_bad_bus
      $error("line_timer_pair: BUS_W must be 8");
   end
   if (CNT_W < 2 || CNT_W > BUS_W) begin : g_bad_cnt
      $error("line_timer_pair: CNT_W out of range");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("line_timer_pair: SYNC_STAGES must be at least 2");
   end
   if (TAP_LOG_A < 1 || TAP_LOG_B <= TAP_LOG_A || TAP_LOG_C <= TAP_LOG_B) begin : g_bad_tap
      $error("line_timer_pair: prescaler taps must be strictly increasing and at least 1");
   end

   logic [BUS_W-1:0] run_q;
   ltp_mode_t        mode_q;
   logic [CNT_W-1:0] cmp_q [N_TIMERS];
   logic [CNT_W-1:0] cnt_w [N_TIMERS];
   logic             hit_w [N_TIMERS];
   logic             req_w [N_TIMERS];
   logic             tick_w[N_TIMERS];
   logic             run_w [N_TIMERS];
   logic [2:0]       taps;
   logic             line_rise;

   // register writes
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         run_q  <= '0;
         mode_q <= '0;
      end else if (wr_en) begin
         case (ltp_addr_e'(addr))
            ADDR_RUN:  run_q  <= wdata;
            ADDR_MODE: mode_q <= ltp_mode_t'(wdata);
            default:   ;
         endcase
      end
   end

   for (genvar t = 0; t < N_TIMERS; t++) begin : g_cmp
      localparam logic [1:0] MY_ADDR = 2'(32'(ADDR_TMR0) + t);
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                          cmp_q[t] <= '0;
         else if (wr_en && addr == MY_ADDR)   cmp_q[t] <= wdata[CNT_W-1:0];
      end
   end

   ltp_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk     (clk),
      .rst_n   (rst_n),
      .async_i (line_in),
      .rise_o  (line_rise)
   );

   ltp_prescaler #(
      .LOG_A (TAP_LOG_A),
      .LOG_B (TAP_LOG_B),
      .LOG_C (TAP_LOG_C)
   ) u_pre (
      .clk    (clk),
      .rst_n  (rst_n),
      .en_i   (run_q[RUN_BIT_PRE]),
      .tick_o (taps)
   );

   // clock source selection
   always_comb begin
      case (mode_q.t0_clk)
         2'b00:   tick_w[0] = line_rise;
         2'b01:   tick_w[0] = taps[0];
         2'b10:   tick_w[0] = taps[1];
         default: tick_w[0] = taps[2];
      endcase
      case (mode_q.t1_clk)
         2'b00:   tick_w[1] = hit_w[0];
         2'b01:   tick_w[1] = taps[0];
         2'b10:   tick_w[1] = taps[1];
         default: tick_w[1] = taps[2];
      endcase
   end

   assign run_w[0] = run_q[RUN_BIT_T0];
   assign run_w[1] = run_q[RUN_BIT_T1];

   for (genvar t = 0; t < N_TIMERS; t++) begin : g_tmr
      ltp_channel #(.CNT_W(CNT_W)) u_ch (
         .clk    (clk),
         .rst_n  (rst_n),
         .run_i  (run_w[t]),
         .tick_i (tick_w[t]),
         .cmp_i  (cmp_q[t]),
         .cnt_o  (cnt_w[t]),
         .hit_o  (hit_w[t]),
         .req_o  (req_w[t])
      );
   end

   // readback: compare addresses return live counters
   always_comb begin
      case (ltp_addr_e'(addr))
         ADDR_RUN:  rdata = run_q;
         ADDR_MODE: rdata = BUS_W'(mode_q);
         ADDR_TMR0: rdata = BUS_W'(cnt_w[0]);
         default:   rdata = BUS_W'(cnt_w[1]);
      endcase
   end

   assign t0_req   = req_w[0];
   assign t1_req   = req_w[1];
   assign req_code = req_w[0] ? VEC0 : (req_w[1] ? VEC1 : 5'h00);
endmodule

// File: rtl/ltp_checker.sv
module ltp_checker #(
   parameter int unsigned CNT_W = 8,
   parameter logic [4:0]  VEC0  = 5'h10
) (
   input logic             clk,
   input logic             rst_n,
   input logic [7:0]       run_q,
   input logic [7:0]       mode_q,
   input logic [CNT_W-1:0] cnt0,
   input logic             t0_req,
   input logic             t1_req,
   input logic [4:0]       req_code
);
   a_r6_stopped_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      !run_q[0] |=> !t0_req);

   a_r6_stopped_cleared: assert property (@(posedge clk) disable iff (!rst_n)
      !run_q[0] |=> (cnt0 == '0));

   a_r10_single_pulse_t0: assert property (@(posedge clk) disable iff (!rst_n)
      t0_req |=> !t0_req);

   a_r10_single_pulse_t1: assert property (@(posedge clk) disable iff (!rst_n)
      t1_req |=> !t1_req);

   a_r4_cascade_aligned: assert property (@(posedge clk) disable iff (!rst_n)
      (t1_req && $past(mode_q[3:2]) == 2'b00 && $past(run_q[1])) |-> t0_req);

   a_r5_prescaler_gate: assert property (@(posedge clk) disable iff (!rst_n)
      (!run_q[7] && mode_q[1:0] != 2'b00) |=> !t0_req);

   a_r9_code_presence: assert property (@(posedge clk) disable iff (!rst_n)
      (req_code != 5'h00) == (t0_req || t1_req));

   a_r9_t0_wins: assert property (@(posedge clk) disable iff (!rst_n)
      t0_req |-> (req_code == VEC0));
endmodule

bind line_timer_pair ltp_checker #(.CNT_W(CNT_W), .VEC0(VEC0)) u_ltp_checker (
   .clk      (clk),
   .rst_n    (rst_n),
   .run_q    (run_q),
   .mode_q   (mode_q),
   .cnt0     (cnt_w[0]),
   .t0_req   (t0_req),
   .t1_req   (t1_req),
   .req_code (req_code)
);

// File: tb/line_timer_pair_bench.sv
`timescale 1ns/1ps
module line_timer_pair_bench;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       line_in = 1'b0;
   logic       wr_en = 1'b0;
   logic [1:0] addr = '0;
   logic [7:0] wdata = '0;
   logic [7:0] rdata;
   logic       t0_req, t1_req;
   logic [4:0] req_code;

   line_timer_pair u_line_timer_pair (
      .clk(clk), .rst_n(rst_n), .line_in(line_in), .wr_en(wr_en),
      .addr(addr), .wdata(wdata), .rdata(rdata),
      .t0_req(t0_req), .t1_req(t1_req), .req_code(req_code)
   );

   always #2.5 clk = ~clk;

   int checks = 0, errors = 0, cyc = 0;
   int exp_q[$];
   bit sb_on = 1'b0;
   int t0_seen = 0, t1_seen = 0, t0_last = 0, t0_prev = 0;
   bit t0_was = 1'b0, t1_was = 1'b0;
   bit done = 1'b0;

   always @(posedge clk) cyc++;

   task automatic chk(input string tag, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s actual=%0d (0x%0h) expected=%0d (0x%0h)", tag, act, act, exp, exp);
      end
   endtask

   task automatic sb_pop(input int id);
      if (exp_q.size() == 0) chk("R2 scoreboard unexpected request", id, -1);
      else chk("R2 scoreboard request order", id, exp_q.pop_front());
   endtask

   // monitor
   always @(negedge clk) begin
      if (rst_n) begin
         if (t0_req) begin
            t0_seen++; t0_prev = t0_last; t0_last = cyc;
            chk("R10 t0 single cycle", int'(t0_was), 0);
         end
         if (t1_req) begin
            t1_seen++;
            chk("R10 t1 single cycle", int'(t1_was), 0);
         end
         if (sb_on) begin
            if (t0_req) sb_pop(0);
            if (t1_req) sb_pop(1);
         end
         if (t0_req)      chk("R9 code timer0", int'(req_code), 'h10);
         else if (t1_req) chk("R9 code timer1", int'(req_code), 'h11);
         t0_was = t0_req;
         t1_was = t1_req;
      end
   end

   task automatic wr(input logic [1:0] a, input logic [7:0] d);
      @(negedge clk); wr_en = 1'b1; addr = a; wdata = d;
      @(negedge clk); wr_en = 1'b0;
   endtask

   task automatic rd(input logic [1:0] a, output int v);
      @(negedge clk); addr = a; #1; v = int'(rdata);
   endtask

   task automatic pulses(input int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk); line_in = 1'b1;
         repeat (2) @(negedge clk);
         line_in = 1'b0;
         repeat (3) @(negedge clk);
      end
   endtask

   task automatic drain();
      repeat (8) @(negedge clk);
   endtask

   task automatic summary();
      $display("CHECKS %0d ERRORS %0d", checks, errors);
   endtask

   initial begin
      #(5.0 * 150000);
      if (!done) begin
         checks++; errors++;
         $display("FAIL watchdog expired");
         summary();
         $finish;
      end
   end

   initial begin
      int v, base0, base1;
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      // R1 reset state
      for (int a = 0; a < 4; a++) begin
         rd(2'(a), v); chk("R1 reset readback", v, 0);
      end
      chk("R1 no request after reset", int'(t0_req | t1_req), 0);

      // R2 compare 1: one request per line edge
      sb_on = 1'b1;
      wr(2, 8'd1); wr(1, 8'h00); wr(0, 8'h01);
      for (int i = 0; i < 5; i++) exp_q.push_back(0);
      pulses(5); drain();
      chk("R2 compare1 all requests seen", exp_q.size(), 0);

      // R2 compare 2: every second edge
      wr(2, 8'd2);
      for (int i = 0; i < 3; i++) exp_q.push_back(0);
      pulses(6); drain();
      chk("R2 compare2 all requests seen", exp_q.size(), 0);

      // R7 live counter readback
      wr(2, 8'd5);
      pulses(3); drain();
      rd(2, v); chk("R7 compare addr returns live count", v, 3);
      rd(0, v); chk("R7 run register readback", v, 'h01);
      exp_q.push_back(0);
      pulses(2); drain();
      chk("R7 fifth edge request", exp_q.size(), 0);

      // R6 stop: no requests, counter held at 0
      wr(0, 8'h00);
      base0 = t0_seen;
      pulses(3); drain();
      chk("R6 stopped timer silent", t0_seen - base0, 0);
      rd(2, v); chk("R6 stopped counter zero", v, 0);

      // R3 compare 0 means 256
      wr(2, 8'd0); wr(0, 8'h01);
      base0 = t0_seen;
      pulses(255); drain();
      chk("R3 no request after 255 edges", t0_seen - base0, 0);
      rd(2, v); chk("R3 counter at 255", v, 255);
      exp_q.push_back(0);
      pulses(1); drain();
      chk("R3 request on 256th edge", exp_q.size(), 0);

      // R4 cascade 152 lines -> 76 timer 1 requests
      wr(2, 8'd1); wr(3, 8'd2); wr(0, 8'h03);
      base0 = t0_seen; base1 = t1_seen;
      for (int i = 0; i < 152; i++) begin
         exp_q.push_back(0);
         if (i % 2 == 1) exp_q.push_back(1);
      end
      pulses(152); drain();
      chk("R4 cascade timer0 count", t0_seen - base0, 152);
      chk("R4 cascade timer1 count", t1_seen - base1, 76);
      chk("R4 scoreboard empty", exp_q.size(), 0);

      // R9 simultaneous requests: timer 0 code wins (monitor checks code)
      wr(3, 8'd1);
      for (int i = 0; i < 2; i++) begin exp_q.push_back(0); exp_q.push_back(1); end
      pulses(2); drain();
      chk("R9 simultaneous scoreboard empty", exp_q.size(), 0);

      // R8 upper mode bits stored and inert
      wr(0, 8'h00); wr(1, 8'hF0);
      rd(1, v); chk("R8 mode readback", v, 'hF0);
      wr(2, 8'd1); wr(0, 8'h01);
      for (int i = 0; i < 3; i++) exp_q.push_back(0);
      pulses(3); drain();
      chk("R8 counting unaffected", exp_q.size(), 0);
      wr(0, 8'h00); wr(1, 8'h00);

      // R5 prescaler taps
      sb_on = 1'b0;
      wr(1, 8'h01); wr(2, 8'd4); wr(0, 8'h01);
      base0 = t0_seen;
      repeat (100) @(negedge clk);
      chk("R5 prescaler off holds tap timer", t0_seen - base0, 0);
      wr(0, 8'h81);
      repeat (60) @(negedge clk);
      chk("R5 clk/2 tap interval", t0_last - t0_prev, 8);
      wr(1, 8'h02);
      repeat (200) @(negedge clk);
      chk("R5 clk/8 tap interval", t0_last - t0_prev, 32);
      wr(0, 8'h00);

      // R9 timer 1 alone on a tap: code 0x11 (monitor)
      wr(1, 8'h04); wr(3, 8'd1);
      base1 = t1_seen;
      wr(0, 8'h82);
      repeat (20) @(negedge clk);
      chk("R5 timer1 on clk/2 tap runs", int'(t1_seen - base1 > 5), 1);
      wr(0, 8'h00);
      drain();

      done = 1'b1;
      summary();
      $finish;
   end
endmodule